// File: doc/BRIEF.md
# Audio FIFO Burst DMA Requester

This block watches the fill levels of an audio serial port's transmit and receive sample FIFOs and asks a DMA controller to move data in bursts. Transmit and receive each drive their own request line. A request is a one-cycle strobe. Every strobe stands for a burst of exactly LIMIT items, where LIMIT is a programmable service threshold. The block never raises a single-item request.

The receive side asks for service once the receive FIFO holds at least LIMIT samples. The transmit side asks for service once the transmit FIFO has room for at least LIMIT samples. After a side issues a strobe, that side stays quiet until it has counted LIMIT pops (receive) or LIMIT pushes (transmit). This stops the same data from being requested twice.

A mask-enable input gates both the request strobes and the interrupt line. Each side also has a sticky status bit that records when its threshold condition was met. Writing 1 to that bit's clear input clears it.

Top module: `afifo_burst_req`

## Requirements
- R1: While reset is applied and after it is released, both request strobes, both status bits and the interrupt are low until a threshold condition arises.
- R2: With the mask set and a nonzero limit, the receive strobe goes high on the clock edge after `rx_level >= limit` holds and the receive side is not waiting on pops.
- R3: With the mask set and a nonzero limit, the transmit strobe goes high on the clock edge after `tx_level + limit <= DEPTH` holds (DEPTH = 8) and the transmit side is not waiting on pushes.
- R4: While `mask_en` is 0, neither request strobe is asserted, whatever the levels are.
- R5: A limit of 0 produces no requests and sets no status. A limit larger than DEPTH can never meet either threshold.
- R6: After a strobe, that side issues no further strobe until it has seen exactly `limit` pops (receive) or pushes (transmit), where the limit is the value captured when the strobe was issued. A pop or push in the cycle the strobe is issued is not counted. Once the count is complete and the condition still holds, the next strobe comes one cycle later.
- R7: Each request is a single-cycle strobe and is never high on two consecutive cycles.
- R8: A status bit is set on every cycle its side's threshold condition holds, whatever the mask is. It stays set until `clr` for that side is pulsed while the condition is false. If a set and a clear arrive in the same cycle, the set wins.
- R9: `irq` equals `mask_en` AND (`tx_stat` OR `rx_stat`).
- R10: The transmit and receive sides act independently. Activity on one side never produces a strobe or a status change on the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| limit | input | 4 | Service limit and burst size; 0 disables requests |
| mask_en | input | 1 | Enables request strobes and the interrupt |
| tx_level | input | 4 | Transmit FIFO occupancy, 0 to 8 |
| tx_push | input | 1 | One item written into the transmit FIFO |
| rx_level | input | 4 | Receive FIFO occupancy, 0 to 8 |
| rx_pop | input | 1 | One item read from the receive FIFO |
| clr_tx | input | 1 | Write-1 clear of the transmit status bit |
| clr_rx | input | 1 | Write-1 clear of the receive status bit |
| tx_req | output | 1 | Transmit burst request strobe |
| rx_req | output | 1 | Receive burst request strobe |
| tx_stat | output | 1 | Sticky transmit threshold status |
| rx_stat | output | 1 | Sticky receive threshold status |
| irq | output | 1 | Level interrupt |

## Verification
An error in a side's hold-off counter shows at that side's request port within one cycle of the pop or push that should end the wait. A wrong count makes the strobe come back early, or come back late or never, even though the level still meets the threshold. A threshold comparison that is off by one shows on the strobe one cycle after the level reaches the boundary value. It also shows on the status bit, which can be seen at the port while the mask is clear. A clear with the wrong priority shows on the status output on the cycle after the clear pulse.

// File: rtl/afifo_burst_req.sv
module afifo_burst_req #(
  parameter int DEPTH = 8,
  parameter int LIMW  = 4,
  localparam int LVLW = $clog2(DEPTH + 1),
  localparam int SUMW = (LVLW > LIMW ? LVLW : LIMW) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LIMW-1:0] limit,
  input  logic            mask_en,
  input  logic [LVLW-1:0] tx_level,
  input  logic            tx_push,
  input  logic [LVLW-1:0] rx_level,
  input  logic            rx_pop,
  input  logic            clr_tx,
  input  logic            clr_rx,
  output logic            tx_req,
  output logic            rx_req,
  output logic            tx_stat,
  output logic            rx_stat,
  output logic            irq
);

  logic [LIMW-1:0] tx_cnt, rx_cnt;
  logic            tx_busy, rx_busy;
  logic [SUMW-1:0] tx_sum;

  wire lim_ok  = (limit != '0);
  assign tx_sum = SUMW'(tx_level) + SUMW'(limit);
  wire tx_cond = lim_ok && (tx_sum <= SUMW'(DEPTH));
  wire rx_cond = lim_ok && (SUMW'(rx_level) >= SUMW'(limit));
  wire tx_fire = mask_en && tx_cond && !tx_busy;
  wire rx_fire = mask_en && rx_cond && !rx_busy;

  assign irq = mask_en && (tx_stat || rx_stat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_req  <= 1'b0;
      tx_busy <= 1'b0;
      tx_cnt  <= '0;
      tx_stat <= 1'b0;
    end else begin
      tx_req  <= tx_fire;
      tx_stat <= tx_cond || (tx_stat && !clr_tx);
      if (tx_fire) begin
        tx_busy <= 1'b1;
        tx_cnt  <= limit;
      end else if (tx_busy && tx_push) begin
        tx_cnt <= tx_cnt - 1'b1;
        if (tx_cnt == LIMW'(1)) tx_busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_req  <= 1'b0;
      rx_busy <= 1'b0;
      rx_cnt  <= '0;
      rx_stat <= 1'b0;
    end else begin
      rx_req  <= rx_fire;
      rx_stat <= rx_cond || (rx_stat && !clr_rx);
      if (rx_fire) begin
        rx_busy <= 1'b1;
        rx_cnt  <= limit;
      end else if (rx_busy && rx_pop) begin
        rx_cnt <= rx_cnt - 1'b1;
        if (rx_cnt == LIMW'(1)) rx_busy <= 1'b0;
      end
    end
  end

  AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n) tx_req |=> !tx_req); // R7
  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rx_req |=> !rx_req); // R7
  AST_TX_MASKED: assert property (@(posedge clk) disable iff (!rst_n) tx_req |-> $past(mask_en)); // R4
  AST_RX_MASKED: assert property (@(posedge clk) disable iff (!rst_n) rx_req |-> $past(mask_en)); // R4
  AST_RX_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) rx_req |-> $past(limit) != '0); // R5
  AST_RX_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n) (rx_busy && !rx_pop) |=> !rx_req); // R6
  AST_TX_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n) (tx_busy && !tx_push) |=> !tx_req); // R6
  AST_RX_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (rx_stat && !clr_rx) |=> rx_stat); // R8
  AST_TX_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (tx_stat && !clr_tx) |=> tx_stat); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) irq |-> mask_en); // R9

endmodule

// File: tb/afifo_burst_req_test.sv
module afifo_burst_req_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] limit = '0;
  logic mask_en = 1'b0;
  logic [3:0] tx_level = 4'd8;
  logic tx_push = 1'b0;
  logic [3:0] rx_level = '0;
  logic rx_pop = 1'b0;
  logic clr_tx = 1'b0;
  logic clr_rx = 1'b0;
  logic tx_req, rx_req, tx_stat, rx_stat, irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  afifo_burst_req uut (
    .clk(clk), .rst_n(rst_n), .limit(limit), .mask_en(mask_en),
    .tx_level(tx_level), .tx_push(tx_push), .rx_level(rx_level), .rx_pop(rx_pop),
    .clr_tx(clr_tx), .clr_rx(clr_rx), .tx_req(tx_req), .rx_req(rx_req),
    .tx_stat(tx_stat), .rx_stat(rx_stat), .irq(irq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; limit = '0; mask_en = 1'b0; tx_level = 4'd8; rx_level = '0;
    tx_push = 1'b0; rx_pop = 1'b0; clr_tx = 1'b0; clr_rx = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(); tick();
    chk("R1 rx_req in reset", rx_req, 1'b0);
    chk("R1 tx_req in reset", tx_req, 1'b0);
    chk("R1 stat in reset", rx_stat | tx_stat, 1'b0);
    rst_n = 1'b1;
    tick();
    chk("R1 irq after reset", irq, 1'b0);
  endtask

  task automatic t_rx_basic();
    do_reset();
    mask_en = 1'b1; limit = 4'd4; rx_level = 4'd3;
    tick();
    chk("R2 rx below limit", rx_req, 1'b0);
    rx_level = 4'd4;
    tick();
    chk("R2 rx at limit", rx_req, 1'b1);
    chk("R10 tx quiet", tx_req, 1'b0);
    tick();
    chk("R7 rx strobe one cycle", rx_req, 1'b0);
    tick(); tick();
    chk("R6 rx held off", rx_req, 1'b0);
    rx_pop = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R6 rx held off during pops", rx_req, 1'b0);
    end
    tick();
    rx_pop = 1'b0;
    chk("R6 rx no strobe on last pop edge", rx_req, 1'b0);
    tick();
    chk("R6 rx re-request after limit pops", rx_req, 1'b1);
  endtask

  task automatic t_tx_basic();
    do_reset();
    mask_en = 1'b1; limit = 4'd3; tx_level = 4'd6;
    tick();
    chk("R3 tx 6+3>8 no request", tx_req, 1'b0);
    tx_level = 4'd5;
    tick();
    chk("R3 tx 5+3=8 request", tx_req, 1'b1);
    chk("R10 rx quiet", rx_req, 1'b0);
    tick();
    chk("R7 tx strobe one cycle", tx_req, 1'b0);
    tx_push = 1'b1;
    tick(); tick();
    tx_push = 1'b0;
    tick();
    chk("R6 tx held after 2 of 3 pushes", tx_req, 1'b0);
    tx_push = 1'b1;
    tick();
    tx_push = 1'b0;
    tick();
    chk("R6 tx re-request after 3 pushes", tx_req, 1'b1);
  endtask

  task automatic t_mask();
    do_reset();
    mask_en = 1'b0; limit = 4'd2; rx_level = 4'd8;
    tick(); tick(); tick();
    chk("R4 rx masked", rx_req, 1'b0);
    chk("R8 rx stat set while masked", rx_stat, 1'b1);
    chk("R9 irq low while masked", irq, 1'b0);
    mask_en = 1'b1;
    tick();
    chk("R4 rx after unmask", rx_req, 1'b1);
    chk("R9 irq high when unmasked", irq, 1'b1);
  endtask

  task automatic t_limit();
    do_reset();
    mask_en = 1'b1; limit = 4'd0; rx_level = 4'd8; tx_level = 4'd0;
    tick(); tick();
    chk("R5 limit0 rx", rx_req, 1'b0);
    chk("R5 limit0 tx", tx_req, 1'b0);
    chk("R5 limit0 stat", rx_stat | tx_stat, 1'b0);
    limit = 4'd9;
    tick(); tick();
    chk("R5 limit9 rx", rx_req, 1'b0);
    chk("R5 limit9 tx", tx_req, 1'b0);
    chk("R5 limit9 stat", rx_stat | tx_stat, 1'b0);
  endtask

  task automatic t_w1c();
    do_reset();
    mask_en = 1'b0; limit = 4'd4; rx_level = 4'd4; tx_level = 4'd8;
    tick(); tick();
    chk("R8 rx stat set", rx_stat, 1'b1);
    chk("R10 tx stat untouched", tx_stat, 1'b0);
    clr_rx = 1'b1;
    tick();
    clr_rx = 1'b0;
    chk("R8 set wins over clear", rx_stat, 1'b1);
    rx_level = 4'd0;
    tick(); tick();
    chk("R8 sticky after condition gone", rx_stat, 1'b1);
    clr_rx = 1'b1;
    tick();
    clr_rx = 1'b0;
    chk("R8 clear with 1", rx_stat, 1'b0);
    tx_level = 4'd0;
    tick();
    chk("R8 tx stat set", tx_stat, 1'b1);
    chk("R10 rx stat unchanged", rx_stat, 1'b0);
  endtask

  initial begin
    #(10 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rx_basic();
    t_tx_basic();
    t_mask();
    t_limit();
    t_w1c();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule